// File: doc/BRIEF.md
# Arbitrated Two-Port Byte-Lane Memory

This block is a synchronous memory with two fully independent access ports, named left and right. Both ports share one clock. Each port has an active-low chip select, an active-low read gate, one active-low write strobe per byte lane, an address and a data path. Either port can reach any word at any time. A write changes only the byte lanes whose strobes are low. A read returns the word one clock after the request, together with a valid flag. While a port writes, its data output stays at zero with the valid flag low.

The block is built in one of two roles, chosen by a parameter. In the master role it watches for both ports selecting the same word in the same cycle. When that happens, the left port wins and the right port sees its busy flag for that cycle. In the slave role there is no local comparison: each port's busy flag comes from an input, so several slave copies can follow one master's decision and together form a wider word.

In both roles a busy port has its writes suppressed, but its reads still complete. Reads always see the word as it stood before the writes of the same cycle.

Top module: `twin_port_bytemem`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits (2048 x 16 by default), and every word can be written and read back from either port.
- R2: Write strobe bit k of a port (active low) controls byte lane k, that is data bits 8k+7..8k. Bit 1 covers bits 15..8 and bit 0 covers bits 7..0. A lane is written only while that strobe and the port's chip select are both low. Lanes whose strobes are high keep their contents.
- R3: In the cycle after any write strobe of a port is low, that port's read data is zero and its valid flag is low, whatever its read gate does.
- R4: When a port's chip select and read gate are low and all of its write strobes are high, the next cycle shows the valid flag high. The read data then equals the addressed word as it was before that cycle's writes. When no such read is requested, the next cycle shows the valid flag low and the data zero.
- R5: In the master role, the right busy output is high in exactly the cycles where both chip selects are low and the two addresses are equal. The left busy output is always low, and the busy inputs have no effect.
- R6: A port whose busy flag is high writes nothing in that cycle, but a read it requests in that cycle still completes as in R4.
- R7: In the slave role, each busy output follows its own busy input in the same cycle, and no address comparison takes place.
- R8: When both ports write the same word in the same cycle and neither is busy, each lane takes the data of the port that strobes it. When both ports strobe the same lane, the left port's data is kept.
- R9: While reset is held and in the first cycle after it, both valid flags are low and both read data buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left read gate, active low |
| l_we_n | input | LANES | Left byte-lane write strobes, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in | input | 1 | Left busy from outside (slave role only) |
| l_busy_out | output | 1 | Left busy flag |
| l_rdata | output | DATA_W | Left read data, registered |
| l_rvalid | output | 1 | Left read data valid |
| r_ce_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right read gate, active low |
| r_we_n | input | LANES | Right byte-lane write strobes, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in | input | 1 | Right busy from outside (slave role only) |
| r_busy_out | output | 1 | Right busy flag |
| r_rdata | output | DATA_W | Right read data, registered |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench drives a master copy and a slave copy with the same stimulus and targets several error-prone cases.

- Same-address collisions where the left port reads and the right port writes. A design that let the right write through would show altered data on a later read.
- Collisions where the left port writes while the right port reads. A design that cancelled the losing read, or returned the new data, would show a missing valid flag or the wrong word.
- Split-lane and same-lane double writes in the slave role. These expose a lane taken from the wrong port.
- Busy inputs pulsed in the master role. A design that obeyed them would drop writes.
- Write strobes combined with a low read gate. A design that leaked read data during a write would show non-zero output.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

   typedef enum logic {
      ROLE_MASTER = 1'b0,
      ROLE_SLAVE  = 1'b1
   } role_e;

   localparam int unsigned DEF_ADDR_W = 11;
   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_LANES  = 2;

endpackage

// File: rtl/tpm_port_ctl.sv
// Per-port decode: turns the active-low controls into lane write enables
// and a read request, with busy suppressing every lane write.
module tpm_port_ctl #(
   parameter int unsigned LANES = tpm_pkg::DEF_LANES
) (
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] we_n,
   input  logic             busy,
   output logic             sel,
   output logic [LANES-1:0] wr_en,
   output logic             rd_req
);

   logic any_strobe;

   assign sel        = ~ce_n;
   assign any_strobe = ~(&we_n);

   for (genvar k = 0; k < LANES; k++) begin : g_lane_en
      assign wr_en[k] = sel & ~we_n[k] & ~busy;
   end

   assign rd_req = sel & ~oe_n & ~any_strobe;

endmodule

// File: rtl/tpm_arbiter.sv
// Busy generation. Master role: same-word collision, left wins.
// Slave role: busy is passed in from outside.
module tpm_arbiter #(
   parameter int unsigned   ADDR_W = tpm_pkg::DEF_ADDR_W,
   parameter tpm_pkg::role_e ROLE  = tpm_pkg::ROLE_MASTER
) (
   input  logic              l_sel,
   input  logic              r_sel,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_in,
   input  logic              r_busy_in,
   output logic              l_busy,
   output logic              r_busy
);

   if (ROLE == tpm_pkg::ROLE_MASTER) begin : g_master
      logic same_word;
      assign same_word = l_sel & r_sel & (l_addr == r_addr);
      assign l_busy    = 1'b0;
      assign r_busy    = same_word;
   end else begin : g_slave
      assign l_busy = l_busy_in;
      assign r_busy = r_busy_in;
   end

endmodule

// File: rtl/tpm_store.sv
// Lane-split storage with two write ports and two registered read ports.
// Reads see contents before the same edge's writes; on a same-lane
// double write the left port is applied last and therefore wins.
module tpm_store #(
   parameter int unsigned ADDR_W = tpm_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W = tpm_pkg::DEF_DATA_W,
   parameter int unsigned LANES  = tpm_pkg::DEF_LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [LANES-1:0]  l_wr_en,
   input  logic [LANES-1:0]  r_wr_en,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              l_rd_req,
   input  logic              r_rd_req,
   output logic [DATA_W-1:0] l_rdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              l_rvalid,
   output logic              r_rvalid
);

   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned LANE_W = DATA_W / LANES;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] l_q, r_q;

      always_ff @(posedge clk) begin
         if (r_wr_en[k]) cells[r_addr] <= r_wdata[k*LANE_W +: LANE_W];
         if (l_wr_en[k]) cells[l_addr] <= l_wdata[k*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            l_q <= '0;
            r_q <= '0;
         end else begin
            l_q <= l_rd_req ? cells[l_addr] : '0;
            r_q <= r_rd_req ? cells[r_addr] : '0;
         end
      end

      assign l_rdata[k*LANE_W +: LANE_W] = l_q;
      assign r_rdata[k*LANE_W +: LANE_W] = r_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_rvalid <= 1'b0;
         r_rvalid <= 1'b0;
      end else begin
         l_rvalid <= l_rd_req;
         r_rvalid <= r_rd_req;
      end
   end

   a_r4_left_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      l_rd_req |=> l_rvalid);
   a_r4_right_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      r_rd_req |=> r_rvalid);
   a_r4_right_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      r_rvalid |-> $past(r_rd_req));
   a_r3_left_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !l_rvalid |-> (l_rdata == '0));
   a_r3_right_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !r_rvalid |-> (r_rdata == '0));

endmodule

// File: rtl/twin_port_bytemem.sv
module twin_port_bytemem #(
   parameter int unsigned    ADDR_W = tpm_pkg::DEF_ADDR_W,
   parameter int unsigned    DATA_W = tpm_pkg::DEF_DATA_W,
   parameter int unsigned    LANES  = tpm_pkg::DEF_LANES,
   parameter tpm_pkg::role_e ROLE   = tpm_pkg::ROLE_MASTER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_oe_n,
   input  logic [LANES-1:0]  l_we_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in,
   output logic              l_busy_out,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   input  logic              r_ce_n,
   input  logic              r_oe_n,
   input  logic [LANES-1:0]  r_we_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in,
   output logic              r_busy_out,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid
);

   if (LANES == 0 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES byte lanes");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end

   logic             l_sel, r_sel;
   logic             l_busy, r_busy;
   logic [LANES-1:0] l_wr_en, r_wr_en;
   logic             l_rd_req, r_rd_req;

   tpm_arbiter #(.ADDR_W(ADDR_W), .ROLE(ROLE)) u_arb (
      .l_sel(l_sel), .r_sel(r_sel),
      .l_addr(l_addr), .r_addr(r_addr),
      .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
      .l_busy(l_busy), .r_busy(r_busy)
   );

   tpm_port_ctl #(.LANES(LANES)) u_lctl (
      .ce_n(l_ce_n), .oe_n(l_oe_n), .we_n(l_we_n), .busy(l_busy),
      .sel(l_sel), .wr_en(l_wr_en), .rd_req(l_rd_req)
   );

   tpm_port_ctl #(.LANES(LANES)) u_rctl (
      .ce_n(r_ce_n), .oe_n(r_oe_n), .we_n(r_we_n), .busy(r_busy),
      .sel(r_sel), .wr_en(r_wr_en), .rd_req(r_rd_req)
   );

   tpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .r_addr(r_addr),
      .l_wr_en(l_wr_en), .r_wr_en(r_wr_en),
      .l_wdata(l_wdata), .r_wdata(r_wdata),
      .l_rd_req(l_rd_req), .r_rd_req(r_rd_req),
      .l_rdata(l_rdata), .r_rdata(r_rdata),
      .l_rvalid(l_rvalid), .r_rvalid(r_rvalid)
   );

   assign l_busy_out = l_busy;
   assign r_busy_out = r_busy;

   a_r6_right_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      r_busy |-> (r_wr_en == '0));
   a_r6_left_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      l_busy |-> (l_wr_en == '0));
   a_r3_write_hides_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_ce_n && !(&l_we_n)) |=> !l_rvalid);
   a_r6_busy_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (r_busy && !r_ce_n && !r_oe_n && (&r_we_n)) |=> r_rvalid);

endmodule

// File: tb/twin_port_bytemem_test.sv
`timescale 1ns/1ps
module twin_port_bytemem_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        lce, loe, rce, roe, bli, bri;
   logic [1:0]  lwe, rwe;
   logic [10:0] la, ra;
   logic [15:0] ld, rd;

   logic        m_lb, m_rb, m_lv, m_rv, s_lb, s_rb, s_lv, s_rv;
   logic [15:0] m_lq, m_rq, s_lq, s_rq;

   twin_port_bytemem #(.ROLE(tpm_pkg::ROLE_MASTER)) uut (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(lce), .l_oe_n(loe), .l_we_n(lwe), .l_addr(la), .l_wdata(ld),
      .l_busy_in(bli), .l_busy_out(m_lb), .l_rdata(m_lq), .l_rvalid(m_lv),
      .r_ce_n(rce), .r_oe_n(roe), .r_we_n(rwe), .r_addr(ra), .r_wdata(rd),
      .r_busy_in(bri), .r_busy_out(m_rb), .r_rdata(m_rq), .r_rvalid(m_rv));

   twin_port_bytemem #(.ROLE(tpm_pkg::ROLE_SLAVE)) uut_slv (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(lce), .l_oe_n(loe), .l_we_n(lwe), .l_addr(la), .l_wdata(ld),
      .l_busy_in(bli), .l_busy_out(s_lb), .l_rdata(s_lq), .l_rvalid(s_lv),
      .r_ce_n(rce), .r_oe_n(roe), .r_we_n(rwe), .r_addr(ra), .r_wdata(rd),
      .r_busy_in(bri), .r_busy_out(s_rb), .r_rdata(s_rq), .r_rvalid(s_rv));

   logic [15:0] ref_m [2048];
   logic [15:0] ref_s [2048];
   int checks = 0;
   int fails  = 0;
   string cur_tag = "";
   bit done = 0;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s): actual %h expected %h", req, cur_tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // One clock of stimulus on both copies, with full checking.
   task automatic step(input logic lc, input logic lo, input logic [1:0] lw,
                       input logic [10:0] a_l, input logic [15:0] d_l,
                       input logic rc, input logic ro, input logic [1:0] rw,
                       input logic [10:0] a_r, input logic [15:0] d_r,
                       input logic bl, input logic br);
      logic coll, lrd, rrd;
      logic [15:0] e_ml, e_mr, e_sl, e_sr;
      lce = lc; loe = lo; lwe = lw; la = a_l; ld = d_l;
      rce = rc; roe = ro; rwe = rw; ra = a_r; rd = d_r;
      bli = bl; bri = br;
      #1;
      coll = !lc && !rc && (a_l == a_r);
      chk("R5", {15'd0, m_lb}, 16'd0);
      chk("R5", {15'd0, m_rb}, {15'd0, coll});
      chk("R7", {15'd0, s_lb}, {15'd0, bl});
      chk("R7", {15'd0, s_rb}, {15'd0, br});
      lrd = !lc && !lo && (lw == 2'b11);
      rrd = !rc && !ro && (rw == 2'b11);
      e_ml = lrd ? ref_m[a_l] : 16'd0;
      e_mr = rrd ? ref_m[a_r] : 16'd0;
      e_sl = lrd ? ref_s[a_l] : 16'd0;
      e_sr = rrd ? ref_s[a_r] : 16'd0;
      for (int k = 0; k < 2; k++) begin
         if (!rc && !rw[k] && !coll) ref_m[a_r][k*8 +: 8] = d_r[k*8 +: 8];
         if (!lc && !lw[k])          ref_m[a_l][k*8 +: 8] = d_l[k*8 +: 8];
         if (!rc && !rw[k] && !br)   ref_s[a_r][k*8 +: 8] = d_r[k*8 +: 8];
         if (!lc && !lw[k] && !bl)   ref_s[a_l][k*8 +: 8] = d_l[k*8 +: 8];
      end
      @(negedge clk);
      chk((lw != 2'b11) ? "R3" : "R4", {15'd0, m_lv}, {15'd0, lrd});
      chk((lw != 2'b11) ? "R3" : "R4", m_lq, e_ml);
      chk((rw != 2'b11) ? "R3" : "R4", {15'd0, m_rv}, {15'd0, rrd});
      chk((rw != 2'b11) ? "R3" : "R4", m_rq, e_mr);
      chk((lw != 2'b11) ? "R3" : "R4", {15'd0, s_lv}, {15'd0, lrd});
      chk((lw != 2'b11) ? "R3" : "R4", s_lq, e_sl);
      chk((rw != 2'b11) ? "R3" : "R4", {15'd0, s_rv}, {15'd0, rrd});
      chk((rw != 2'b11) ? "R3" : "R4", s_rq, e_sr);
   endtask

   task automatic idle();
      step(1, 1, 2'b11, 0, 0, 1, 1, 2'b11, 0, 0, 0, 0);
   endtask
   task automatic rd_l(input logic [10:0] a);
      step(0, 0, 2'b11, a, 0, 1, 1, 2'b11, 0, 0, 0, 0);
   endtask
   task automatic rd_r(input logic [10:0] a);
      step(1, 1, 2'b11, 0, 0, 0, 0, 2'b11, a, 0, 0, 0);
   endtask

   task automatic t_reset();
      cur_tag = "R9 reset";
      lce = 1; loe = 1; lwe = 2'b11; la = 0; ld = 0;
      rce = 1; roe = 1; rwe = 2'b11; ra = 0; rd = 0; bli = 0; bri = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R9", {14'd0, m_lv, m_rv}, 16'd0);
      chk("R9", m_lq | m_rq, 16'd0);
      chk("R9", {14'd0, s_lv, s_rv}, 16'd0);
      chk("R9", s_lq | s_rq, 16'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R9", {14'd0, m_lv, s_rv}, 16'd0);
   endtask

   task automatic t_fill();
      cur_tag = "R1 fill";
      for (int i = 0; i < 1024; i++)
         step(1, 1, 2'b00, 11'(i), 16'(i * 16'h9e37 + 1),
              0, 1, 2'b00, 11'(i + 1024), 16'(i * 16'h3b1d + 7), 0, 0);
      rd_l(0); rd_r(2047); rd_l(1023); rd_r(1024); rd_r(0); rd_l(2047);
   endtask

   task automatic t_lanes();
      cur_tag = "R2 lanes";
      step(0, 1, 2'b01, 5, 16'hAB00, 1, 1, 2'b11, 0, 0, 0, 0);
      rd_l(5);
      step(1, 1, 2'b11, 0, 0, 0, 1, 2'b10, 5, 16'h00CD, 0, 0);
      rd_r(5);
      // strobes low but chip select high: nothing written
      step(1, 1, 2'b00, 5, 16'h1111, 1, 1, 2'b00, 5, 16'h2222, 0, 0);
      rd_l(5);
      chk("R2", ref_m[5], 16'hABCD);
   endtask

   task automatic t_hide();
      cur_tag = "R3 write hides output";
      step(0, 0, 2'b00, 9, 16'h5A5A, 0, 0, 2'b01, 10, 16'hC3C3, 0, 0);
      step(0, 0, 2'b10, 9, 16'h0077, 1, 1, 2'b11, 0, 0, 0, 0);
      rd_l(9); rd_r(10);
   endtask

   task automatic t_latency();
      cur_tag = "R4 reads";
      rd_l(100); rd_l(101); rd_r(200);
      step(0, 0, 2'b11, 300, 0, 0, 0, 2'b11, 301, 0, 0, 0);
      step(0, 1, 2'b11, 300, 0, 0, 1, 2'b11, 301, 0, 0, 0);
   endtask

   task automatic t_collide();
      cur_tag = "R6 collision";
      // left reads, right writes same word: right blocked in master
      step(0, 0, 2'b11, 40, 0, 0, 1, 2'b00, 40, 16'hDEAD, 0, 0);
      rd_l(40);
      // left writes, right reads same word: old data returned
      step(0, 1, 2'b00, 41, 16'hBEEF, 0, 0, 2'b11, 41, 0, 0, 0);
      rd_r(41);
      cur_tag = "R5 no collision";
      step(0, 0, 2'b11, 42, 0, 0, 0, 2'b11, 43, 0, 0, 0);
      step(0, 0, 2'b11, 44, 0, 1, 0, 2'b11, 44, 0, 0, 0);
      cur_tag = "R5 busy inputs ignored in master";
      step(0, 1, 2'b00, 45, 16'h4545, 0, 1, 2'b00, 46, 16'h4646, 1, 1);
      rd_l(45); rd_r(46);
   endtask

   task automatic t_slave();
      cur_tag = "R7 slave busy input";
      step(0, 1, 2'b00, 60, 16'h6060, 1, 1, 2'b11, 0, 0, 1, 0);
      step(0, 0, 2'b11, 60, 0, 0, 1, 2'b00, 61, 16'h6161, 1, 1);
      rd_l(60); rd_r(61);
      cur_tag = "R8 split lanes";
      step(0, 1, 2'b01, 70, 16'h1200, 0, 1, 2'b10, 70, 16'h0034, 0, 0);
      rd_l(70);
      cur_tag = "R8 same lane";
      step(0, 1, 2'b00, 71, 16'hAAAA, 0, 1, 2'b00, 71, 16'h5555, 0, 0);
      rd_r(71);
      chk("R8", ref_s[70], 16'h1234);
   endtask

   task automatic t_random();
      cur_tag = "R6 random traffic";
      for (int i = 0; i < 3000; i++) begin
         logic [10:0] a1, a2;
         a1 = 11'($urandom_range(0, 63));
         a2 = ($urandom_range(0, 3) == 0) ? a1 : 11'($urandom_range(0, 63));
         step(1'($urandom_range(0, 4) == 0), 1'($urandom), 2'($urandom), a1, 16'($urandom),
              1'($urandom_range(0, 4) == 0), 1'($urandom), 2'($urandom), a2, 16'($urandom),
              1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
      end
      for (int i = 0; i < 64; i++) rd_l(11'(i));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_fill();
      t_lanes();
      t_hide();
      t_latency();
      t_collide();
      t_slave();
      t_random();
      idle();
      summary();
   end

endmodule